// File: doc/BRIEF.md
# Fused 128/64 Unsigned Divide with Remainder

This unit divides a double-width unsigned dividend by a single-width unsigned divisor and returns the quotient and the remainder together. The dividend is built from two word operands: the high word supplies the upper half and the low word supplies the lower half. The divisor is one word wide. With the default word width of 64 this is a 128-by-64 division that gives a 64-bit quotient and a 64-bit remainder.

A caller pulses `start` with the operands and a destination index. The quotient is tagged for that index. The remainder is tagged for the next index up, which wraps at the top of the index range. A one-cycle `done` pulse marks the cycle in which both results and both tags are valid.

Two cases cannot produce a quotient that fits in one word: a zero divisor, and a high word that is not below the divisor. The unit checks for both as soon as it accepts the request. In either case it finishes at once with a quotient of all ones and a remainder of zero, so software can recognise the error from the results alone. A status bit, `ovf`, reports the same condition so that tests can observe it. The division itself is a radix-2 restoring loop that takes one quotient bit per cycle.

Top module: `divmod_wide`

## Requirements
- R1: After reset, `busy`, `done` and `ovf` are 0, and `quot` and `rem` are 0.
- R2: A start with a non-zero divisor and a high word strictly below the divisor produces `quot` = floor(({hi,lo}) / div) and `rem` = ({hi,lo}) mod div, where `hi` occupies the upper W bits of the dividend. Consequently `quot`*div + `rem` equals the dividend and `rem` < div.
- R3: A start with a zero divisor, or with a high word greater than or equal to the divisor, produces `quot` = all ones, `rem` = 0 and `ovf` = 1. A valid division produces `ovf` = 0.
- R4: For a valid division, `done` is high after the W+1-th rising edge, counting the edge that accepts `start`. For a guarded case, `done` is high after that accepting edge itself.
- R5: `done` is a one-cycle pulse unless a new start is accepted in that cycle. `quot`, `rem`, `ovf` and the index outputs hold their values until the next completion.
- R6: When `done` is high, `quot_idx` equals the index given with the start, and `rem_idx` equals that index plus one, modulo 2^IW.
- R7: `busy` is high while a valid division is in progress. A `start` presented while `busy` is high is ignored and does not change the result of the division in progress.
- R8: `busy` is low in the `done` cycle, so a `start` in that same cycle is accepted and runs to completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled when not busy |
| op_hi | input | W | Upper word of the dividend |
| op_lo | input | W | Lower word of the dividend |
| op_div | input | W | Divisor |
| dst_idx | input | IW | Destination index for the quotient |
| busy | output | 1 | Division loop running |
| done | output | 1 | Results valid pulse |
| quot | output | W | Quotient word |
| rem | output | W | Remainder word |
| quot_idx | output | IW | Index tag for the quotient |
| rem_idx | output | IW | Index tag for the remainder (quotient index plus one) |
| ovf | output | 1 | Guard failed, fixed outputs produced |

## Verification
Completion of one request and acceptance of the next can fall in the same cycle, because `busy` is already low when `done` is raised. The bench provokes this by holding `start` with fresh operands in the very cycle it sees `done`. It then checks that the first results were intact in that cycle, and that the second request, a guarded case, completes one edge later with its own values. A further sweep over an 8-bit configuration covers every divisor with high words at zero, at half the divisor, just below it, equal to it and at all ones. Every result is compared against arithmetic computed in the bench.

// File: rtl/divmod_pkg.sv
package divmod_pkg;
  typedef enum logic [0:0] {
    DM_IDLE = 1'b0,
    DM_RUN  = 1'b1
  } dm_state_e;
endpackage

// File: rtl/divmod_guard.sv
module divmod_guard #(
  parameter int W = 64
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] div,
  output logic         bad
);
  logic div_zero;
  logic hi_fits;

  always_comb begin
    div_zero = (div == '0);
    hi_fits  = (hi < div);
    bad      = div_zero | ~hi_fits;
  end
endmodule

// File: rtl/divmod_step.sv
module divmod_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] part_rem,
  input  logic [W-1:0] shreg,
  input  logic [W-1:0] div,
  output logic [W-1:0] part_rem_nx,
  output logic [W-1:0] shreg_nx
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       take;

  always_comb begin
    trial       = {part_rem, shreg[W-1]};
    diff        = trial - {1'b0, div};
    take        = (trial >= {1'b0, div});
    part_rem_nx = take ? diff[W-1:0] : trial[W-1:0];
    shreg_nx    = {shreg[W-2:0], take};
  end
endmodule

// File: rtl/divmod_ctrl.sv
module divmod_ctrl
  import divmod_pkg::*;
#(
  parameter int W = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic guard_bad,
  output logic busy,
  output logic load,
  output logic step,
  output logic fin_ok,
  output logic fin_bad,
  output logic done
);
  localparam int CW = $clog2(W + 1);

  dm_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    fin_ok  = 1'b0;
    fin_bad = 1'b0;
    unique case (state_q)
      DM_IDLE: begin
        if (start) begin
          if (guard_bad) begin
            fin_bad = 1'b1;
          end else begin
            load    = 1'b1;
            cnt_en  = 1'b1;
            cnt_d   = CW'(W);
            state_d = DM_RUN;
          end
        end
      end
      DM_RUN: begin
        step   = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          fin_ok  = 1'b1;
          state_d = DM_IDLE;
        end
      end
      default: state_d = DM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DM_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok | fin_bad;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q == DM_RUN);
  assign done = done_q;

  // R7
  run_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/divmod_wide.sv
module divmod_wide #(
  parameter int W  = 64,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  op_hi,
  input  logic [W-1:0]  op_lo,
  input  logic [W-1:0]  op_div,
  input  logic [IW-1:0] dst_idx,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  quot,
  output logic [W-1:0]  rem,
  output logic [IW-1:0] quot_idx,
  output logic [IW-1:0] rem_idx,
  output logic          ovf
);
  logic rst_m, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic guard_bad, load, step, fin_ok, fin_bad;

  divmod_guard #(.W(W)) u_guard (
    .hi  (op_hi),
    .div (op_div),
    .bad (guard_bad)
  );

  divmod_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .start     (start),
    .guard_bad (guard_bad),
    .busy      (busy),
    .load      (load),
    .step      (step),
    .fin_ok    (fin_ok),
    .fin_bad   (fin_bad),
    .done      (done)
  );

  logic [W-1:0]  prem_q, prem_d, shr_q, shr_d, div_q;
  logic [W-1:0]  prem_nx, shr_nx;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  quot_q, quot_d, rem_q, rem_d;
  logic [IW-1:0] qidx_q, qidx_d;
  logic          ovf_q, ovf_d, out_en;

  divmod_step #(.W(W)) u_step (
    .part_rem    (prem_q),
    .shreg       (shr_q),
    .div         (div_q),
    .part_rem_nx (prem_nx),
    .shreg_nx    (shr_nx)
  );

  always_comb begin
    prem_d = load ? op_hi : prem_nx;
    shr_d  = load ? op_lo : shr_nx;
    out_en = fin_ok | fin_bad;
    quot_d = fin_bad ? '1 : shr_nx;
    rem_d  = fin_bad ? '0 : prem_nx;
    qidx_d = fin_bad ? dst_idx : idx_q;
    ovf_d  = fin_bad;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      prem_q <= '0;
      shr_q  <= '0;
      div_q  <= '0;
      idx_q  <= '0;
      quot_q <= '0;
      rem_q  <= '0;
      qidx_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (load | step) begin
        prem_q <= prem_d;
        shr_q  <= shr_d;
      end
      if (load) begin
        div_q <= op_div;
        idx_q <= dst_idx;
      end
      if (out_en) begin
        quot_q <= quot_d;
        rem_q  <= rem_d;
        qidx_q <= qidx_d;
        ovf_q  <= ovf_d;
      end
    end
  end

  assign quot     = quot_q;
  assign rem      = rem_q;
  assign quot_idx = qidx_q;
  assign rem_idx  = qidx_q + 1'b1;
  assign ovf      = ovf_q;

  // R3
  guard_out_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (done && ovf) |-> (quot == '1 && rem == '0));
  // R2
  rem_lt_div_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (done && !ovf) |-> (rem < div_q));
  // R2
  part_rem_chk: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> (prem_q < div_q));
  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!done && !$past(out_en)) |-> ($stable(quot) && $stable(rem) && $stable(ovf)));
  // R7
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && start) |=> (busy || done));
endmodule

// File: tb/divmod_wide_tb.sv
module divmod_wide_tb;
  localparam int W  = 8;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  op_hi = '0, op_lo = '0, op_div = '0;
  logic [IW-1:0] dst_idx = '0;
  logic          busy, done, ovf;
  logic [W-1:0]  quot, rem;
  logic [IW-1:0] quot_idx, rem_idx;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  divmod_wide #(.W(W), .IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_hi(op_hi), .op_lo(op_lo), .op_div(op_div), .dst_idx(dst_idx),
    .busy(busy), .done(done), .quot(quot), .rem(rem),
    .quot_idx(quot_idx), .rem_idx(rem_idx), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_res(input int hi, input int lo, input int dv, input int idx);
    int dd, eq, er;
    bit g;
    dd = hi * 256 + lo;
    g  = (dv == 0) || (hi >= dv);
    eq = g ? 255 : dd / dv;
    er = g ? 0 : dd % dv;
    chk(quot == W'(eq), g ? "R3 quot" : "R2 quot", quot, eq);
    chk(rem == W'(er), g ? "R3 rem" : "R2 rem", rem, er);
    chk(ovf == g, "R3 ovf", ovf, g);
    if (!g) chk(int'(quot) * dv + int'(rem) == dd && int'(rem) < dv,
                "R2 identity", int'(quot) * dv + int'(rem), dd);
    chk(quot_idx == IW'(idx) && rem_idx == IW'(idx + 1), "R6 idx",
        {quot_idx, rem_idx}, {IW'(idx), IW'(idx + 1)});
  endtask

  // drive at negedge; returns number of rising edges until done seen
  task automatic run_op(input int hi, input int lo, input int dv, input int idx, output int lat);
    op_hi = W'(hi); op_lo = W'(lo); op_div = W'(dv); dst_idx = IW'(idx);
    start = 1'b1;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
      start = 1'b0;
    end while (!done && lat < 40);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int lat;
    int his[5];
    int los[3];
    los = '{0, 8'hA5, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !ovf, "R1 flags", {busy, done, ovf}, 0);
    chk(quot == '0 && rem == '0, "R1 outputs", {quot, rem}, 0);

    // R4 latencies, R5 pulse and hold
    run_op(8'h12, 8'h34, 8'h56, 3, lat);
    chk(lat == W + 1, "R4 valid latency", lat, W + 1);
    expect_res(8'h12, 8'h34, 8'h56, 3);
    @(negedge clk);
    chk(!done, "R5 done pulse", done, 0);
    repeat (4) @(negedge clk);
    expect_res(8'h12, 8'h34, 8'h56, 3);
    run_op(8'h40, 8'h00, 8'h00, 7, lat);
    chk(lat == 1, "R4 guard latency", lat, 1);
    expect_res(8'h40, 8'h00, 8'h00, 7);
    run_op(8'h33, 8'hFF, 8'h33, 31, lat);
    expect_res(8'h33, 8'hFF, 8'h33, 31);
    run_op(8'hFE, 8'hFF, 8'hFF, 31, lat);
    expect_res(8'hFE, 8'hFF, 8'hFF, 31);
    run_op(8'hFF, 8'hFF, 8'hFF, 0, lat);
    expect_res(8'hFF, 8'hFF, 8'hFF, 0);

    // R7 start while busy is ignored
    op_hi = 8'h01; op_lo = 8'h02; op_div = 8'h09; dst_idx = 5'd4; start = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(busy, "R7 busy", busy, 1);
    op_hi = 8'h00; op_lo = 8'h00; op_div = 8'h00; dst_idx = 5'd9;
    repeat (2) @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    expect_res(8'h01, 8'h02, 8'h09, 4);
    @(negedge clk);
    chk(!done && !busy, "R7 no extra op", {done, busy}, 0);

    // R8 start in the done cycle
    run_op(8'h05, 8'h77, 8'h80, 12, lat);
    expect_res(8'h05, 8'h77, 8'h80, 12);
    op_hi = 8'h90; op_lo = 8'h11; op_div = 8'h90; dst_idx = 5'd20; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(done, "R8 back-to-back done", done, 1);
    expect_res(8'h90, 8'h11, 8'h90, 20);

    // sweep: every divisor, selected high words and low words
    for (int dv = 0; dv < 256; dv++) begin
      his = '{0, (dv > 0) ? dv - 1 : 0, dv, dv / 2, 255};
      for (int h = 0; h < 5; h++) begin
        for (int l = 0; l < 3; l++) begin
          run_op(his[h], los[l], dv, (dv + h) % 32, lat);
          chk(lat == (((dv == 0) || (his[h] >= dv)) ? 1 : W + 1), "R4 sweep latency",
              lat, ((dv == 0) || (his[h] >= dv)) ? 1 : W + 1);
          expect_res(his[h], los[l], dv, (dv + h) % 32);
        end
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule